// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit resolves read-after-write hazards for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it is given the register fields of the instruction sitting in decode: two source indices with their use flags, a destination index, a write enable and a load flag. It carries these fields down three internal stage registers (decode/execute, execute/memory, memory/writeback). From them it produces a bypass select for each ALU operand of the instruction in execute and a stall that holds the decode instruction for one cycle behind a load whose result it needs.

Registers are read only in decode and written only in writeback, and the register file writes before it reads within a cycle. Read-after-write is therefore the only hazard that needs handling. A producer three slots ahead reaches its consumer through the register file, so two bypass sources are enough. While the stall is high, the surrounding pipeline freezes its PC and fetch/decode register. This unit puts a bubble into its own decode/execute fields in place of the held instruction.

Top module: `hazard_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, both selects read 2'b00 and the stall is 0, whatever the decode fields hold.
- R2: An operand of the execute instruction selects 2'b10 (execute/memory result) when its use flag is set, its index is nonzero, and the execute/memory producer has write enable set and the same destination.
- R3: An operand selects 2'b01 (memory/writeback result) when the execute/memory stage does not match it and the memory/writeback producer writes the same nonzero register.
- R4: When both later stages match one operand, the execute/memory source (2'b10) wins.
- R5: With no matching producer in either later stage, the select is 2'b00 (register-file value). This includes a producer three instructions ahead, which has already left writeback.
- R6: The stall is 1 when the decode/execute instruction is a load with write enable and a nonzero destination, and an enabled decode source names that destination.
- R7: A stall lasts one cycle. The held instruction then enters execute behind a bubble and takes the loaded value with select 2'b01.
- R8: Register index 0 never yields a nonzero select and never raises the stall.
- R9: A producer with write enable clear, and a source whose use flag is clear, take no part in forwarding or stall detection.
- R10: The second and third instructions after a load get its data through forwarding (2'b01 for the second, register file for the third) without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs1_i | input | REG_W | First source index of the decode instruction |
| id_rs2_i | input | REG_W | Second source index of the decode instruction |
| id_rs1_en_i | input | 1 | First source is read |
| id_rs2_en_i | input | 1 | Second source is read |
| id_rd_i | input | REG_W | Destination index of the decode instruction |
| id_we_i | input | 1 | Decode instruction writes its destination |
| id_load_i | input | 1 | Decode instruction is a load |
| fwd_a_o | output | 2 | Select for ALU operand A: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b_o | output | 2 | Select for ALU operand B, same encoding |
| stall_o | output | 1 | Hold PC and fetch/decode; bubble into decode/execute |

## Verification
A corrupted stage register shows up at the selects one or two cycles after the bad entry. A bubble that keeps a write enable, or a stage that fails to advance, gives a select that names a stage no longer holding the producer. A stale decode/execute load flag raises a stall, or withholds one, in the very cycle the consumer reaches decode. A missing bubble shows in the next cycle as a second stall, or as a 2'b10 select where 2'b01 was due. The random mix uses only a few register indices, so back-to-back, gap-of-one and gap-of-two dependences, and index 0 cases, come up often.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'b00,
    FWD_MW = 2'b01,
    FWD_EM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hz_stage_regs.sv
module hz_stage_regs #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NSRC  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bubble_i,
  input  logic [NSRC-1:0][REG_W-1:0] id_rs_i,
  input  logic [NSRC-1:0]            id_rs_en_i,
  input  logic [REG_W-1:0]           id_rd_i,
  input  logic                       id_we_i,
  input  logic                       id_load_i,
  output logic [NSRC-1:0][REG_W-1:0] ex_rs_o,
  output logic [NSRC-1:0]            ex_rs_en_o,
  output logic [REG_W-1:0]           ex_rd_o,
  output logic                       ex_we_o,
  output logic                       ex_load_o,
  output logic [REG_W-1:0]           em_rd_o,
  output logic                       em_we_o,
  output logic [REG_W-1:0]           mw_rd_o,
  output logic                       mw_we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_rs_o    <= '0;
      ex_rs_en_o <= '0;
      ex_rd_o    <= '0;
      ex_we_o    <= 1'b0;
      ex_load_o  <= 1'b0;
      em_rd_o    <= '0;
      em_we_o    <= 1'b0;
      mw_rd_o    <= '0;
      mw_we_o    <= 1'b0;
    end else begin
      if (bubble_i) begin
        ex_rs_o    <= '0;
        ex_rs_en_o <= '0;
        ex_rd_o    <= '0;
        ex_we_o    <= 1'b0;
        ex_load_o  <= 1'b0;
      end else begin
        ex_rs_o    <= id_rs_i;
        ex_rs_en_o <= id_rs_en_i;
        ex_rd_o    <= id_rd_i;
        ex_we_o    <= id_we_i;
        ex_load_o  <= id_load_i;
      end
      em_rd_o <= ex_rd_o;
      em_we_o <= ex_we_o;
      mw_rd_o <= em_rd_o;
      mw_we_o <= em_we_o;
    end
  end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             src_en_i,
  input  logic [REG_W-1:0] em_rd_i,
  input  logic             em_we_i,
  input  logic [REG_W-1:0] mw_rd_i,
  input  logic             mw_we_i,
  output fwd_sel_e         sel_o
);
  logic live;
  assign live = src_en_i && (src_i != '0);

  always_comb begin
    sel_o = FWD_RF;
    if (live && em_we_i && (em_rd_i == src_i))      sel_o = FWD_EM;
    else if (live && mw_we_i && (mw_rd_i == src_i)) sel_o = FWD_MW;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] id_rs_i,
  input  logic [NSRC-1:0]            id_rs_en_i,
  input  logic [REG_W-1:0]           ex_rd_i,
  input  logic                       ex_we_i,
  input  logic                       ex_load_i,
  output logic                       stall_o
);
  logic [NSRC-1:0] hit;
  logic            ld_live;
  assign ld_live = ex_load_i && ex_we_i && (ex_rd_i != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = id_rs_en_i[s] && (id_rs_i[s] == ex_rd_i);
  end

  assign stall_o = ld_live && (|hit);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_rs1_en_i,
  input  logic             id_rs2_en_i,
  input  logic [REG_W-1:0] id_rd_i,
  input  logic             id_we_i,
  input  logic             id_load_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             stall_o
);
  localparam int unsigned NSRC = NUM_SRC;

  logic [NSRC-1:0][REG_W-1:0] id_rs, ex_rs;
  logic [NSRC-1:0]            id_rs_en, ex_rs_en;
  logic [REG_W-1:0]           ex_rd, em_rd, mw_rd;
  logic                       ex_we, ex_load, em_we, mw_we;
  logic                       stall;
  fwd_sel_e                   sel [NSRC];

  assign id_rs    = {id_rs2_i, id_rs1_i};
  assign id_rs_en = {id_rs2_en_i, id_rs1_en_i};

  hz_load_use #(.REG_W(REG_W), .NSRC(NSRC)) u_lu (
    .id_rs_i    (id_rs),
    .id_rs_en_i (id_rs_en),
    .ex_rd_i    (ex_rd),
    .ex_we_i    (ex_we),
    .ex_load_i  (ex_load),
    .stall_o    (stall)
  );

  hz_stage_regs #(.REG_W(REG_W), .NSRC(NSRC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bubble_i   (stall),
    .id_rs_i    (id_rs),
    .id_rs_en_i (id_rs_en),
    .id_rd_i    (id_rd_i),
    .id_we_i    (id_we_i),
    .id_load_i  (id_load_i),
    .ex_rs_o    (ex_rs),
    .ex_rs_en_o (ex_rs_en),
    .ex_rd_o    (ex_rd),
    .ex_we_o    (ex_we),
    .ex_load_o  (ex_load),
    .em_rd_o    (em_rd),
    .em_we_o    (em_we),
    .mw_rd_o    (mw_rd),
    .mw_we_o    (mw_we)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    hz_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src_i    (ex_rs[s]),
      .src_en_i (ex_rs_en[s]),
      .em_rd_i  (em_rd),
      .em_we_i  (em_we),
      .mw_rd_i  (mw_rd),
      .mw_we_i  (mw_we),
      .sel_o    (sel[s])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];
  assign stall_o = stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] id_rs1_i,
  input logic [REG_W-1:0] id_rs2_i,
  input logic             id_rs1_en_i,
  input logic             id_rs2_en_i,
  input logic [REG_W-1:0] id_rd_i,
  input logic             id_we_i,
  input logic             id_load_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             stall_o
);
  AST_STALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o); // R7

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11)); // R2

  AST_ZERO_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!id_rs1_en_i || id_rs1_i == '0) && (!id_rs2_en_i || id_rs2_i == '0)) |-> !stall_o); // R8

  AST_LOAD_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(stall_o) && $past(id_load_i && id_we_i && id_rd_i != '0)
     && id_rs1_en_i && id_rs1_i == $past(id_rd_i)) |-> stall_o); // R6

  AST_FWD_EM_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 1) && $past(rst_ni, 2) && !$past(stall_o, 1) && !$past(stall_o, 2)
     && $past(id_rs1_en_i, 1) && $past(id_rs1_i, 1) != '0 && $past(id_we_i, 2)
     && $past(id_rs1_i, 1) == $past(id_rd_i, 2)) |-> fwd_a_o == 2'b10); // R4
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .id_rs1_i    (id_rs1_i),
  .id_rs2_i    (id_rs2_i),
  .id_rs1_en_i (id_rs1_en_i),
  .id_rs2_en_i (id_rs2_en_i),
  .id_rd_i     (id_rd_i),
  .id_we_i     (id_we_i),
  .id_load_i   (id_load_i),
  .fwd_a_o     (fwd_a_o),
  .fwd_b_o     (fwd_b_o),
  .stall_o     (stall_o)
);

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 5;

  typedef struct packed {
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic             e1;
    logic             e2;
    logic [REG_W-1:0] rd;
    logic             we;
    logic             ld;
  } ins_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [REG_W-1:0] rs1, rs2, rd;
  logic             e1, e2, we, ld;
  logic [1:0]       fa, fb;
  logic             st;

  int n_chk = 0;
  int n_bad = 0;

  ins_t ie, em, mw;
  logic held = 1'b0;
  logic was_stall = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_unit #(.REG_W(REG_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(rs1), .id_rs2_i(rs2), .id_rs1_en_i(e1), .id_rs2_en_i(e2),
    .id_rd_i(rd), .id_we_i(we), .id_load_i(ld),
    .fwd_a_o(fa), .fwd_b_o(fb), .stall_o(st)
  );

  function automatic ins_t mk(input int s1, input int s2, input bit en1, input bit en2,
                              input int d, input bit w, input bit l);
    ins_t i;
    i.rs1 = REG_W'(s1); i.rs2 = REG_W'(s2); i.e1 = en1; i.e2 = en2;
    i.rd = REG_W'(d); i.we = w; i.ld = l;
    return i;
  endfunction

  function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] s, input logic en);
    if (en && s != 0 && em.we && em.rd == s) return 2'b10;
    if (en && s != 0 && mw.we && mw.rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [REG_W-1:0] s, input logic en, input logic [1:0] e);
    if (s == 0 && ((em.rd == 0 && em.we) || (mw.rd == 0 && mw.we))) return "R8";
    if (en && ((em.rd == s && !em.we) || (mw.rd == s && !mw.we))) return "R9";
    if (e == 2'b10 && mw.we && mw.rd == s) return "R4";
    if (e == 2'b10) return "R2";
    if (e == 2'b01 && was_stall) return "R7";
    if (e == 2'b01 && mw.ld) return "R10";
    if (e == 2'b01) return "R3";
    return "R5";
  endfunction

  function automatic logic exp_stall(input ins_t c);
    return ie.ld && ie.we && ie.rd != 0 &&
           ((c.e1 && c.rs1 == ie.rd) || (c.e2 && c.rs2 == ie.rd));
  endfunction

  task automatic check(input string r, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic drive(input ins_t i);
    rs1 = i.rs1; rs2 = i.rs2; e1 = i.e1; e2 = i.e2; rd = i.rd; we = i.we; ld = i.ld;
  endtask

  task automatic step(input ins_t i);
    logic s;
    @(negedge clk);
    drive(i);
    #1;
    check(sel_tag(ie.rs1, ie.e1, exp_sel(ie.rs1, ie.e1)), fa, exp_sel(ie.rs1, ie.e1));
    check(sel_tag(ie.rs2, ie.e2, exp_sel(ie.rs2, ie.e2)), fb, exp_sel(ie.rs2, ie.e2));
    s = exp_stall(i);
    check(was_stall ? "R7" : (((i.rs1 == 0 || !i.e1) && (i.rs2 == 0 || !i.e2)) ? "R8" : "R6"),
          {1'b0, st}, {1'b0, s});
    @(posedge clk);
    mw = em; em = ie;
    ie = s ? '0 : i;
    held = s;
    was_stall = s;
  endtask

  task automatic issue(input ins_t i);
    step(i);
    while (held) step(i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ie = '0; em = '0; mw = '0;
    drive(mk(3, 3, 1, 1, 3, 1, 1));
    repeat (3) @(negedge clk);
    #1;
    check("R1", fa, 2'b00);
    check("R1", fb, 2'b00);
    check("R1", {1'b0, st}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(mk(0, 0, 0, 0, 0, 0, 0));
    #1;
    check("R1", {1'b0, st}, 2'b00);

    // ALU chain: back-to-back, gap one, gap two (three ahead reads regfile)
    issue(mk(2, 3, 1, 1, 1, 1, 0));
    issue(mk(1, 4, 1, 1, 5, 1, 0));
    issue(mk(4, 1, 1, 1, 6, 1, 0));
    issue(mk(1, 1, 1, 1, 7, 1, 0));
    issue(mk(0, 0, 0, 0, 0, 0, 0));
    // priority: same rd written twice in a row
    issue(mk(0, 0, 0, 0, 8, 1, 0));
    issue(mk(0, 0, 0, 0, 8, 1, 0));
    issue(mk(8, 8, 1, 1, 9, 1, 0));
    // load-use then second and third after the load
    issue(mk(2, 0, 1, 0, 10, 1, 1));
    issue(mk(10, 0, 1, 0, 11, 1, 0));
    issue(mk(0, 10, 0, 1, 12, 1, 0));
    issue(mk(10, 10, 1, 1, 13, 1, 0));
    issue(mk(0, 0, 0, 0, 0, 0, 0));
    issue(mk(0, 0, 0, 0, 0, 0, 0));
    // load with gap: no stall, forwarded from later stage
    issue(mk(0, 0, 0, 0, 14, 1, 1));
    issue(mk(0, 0, 0, 0, 15, 1, 0));
    issue(mk(14, 0, 1, 0, 16, 1, 0));
    // r0 producer / consumer, load to r0
    issue(mk(0, 0, 0, 0, 0, 1, 1));
    issue(mk(0, 0, 1, 1, 17, 1, 0));
    issue(mk(0, 0, 1, 1, 18, 1, 0));
    // write enable clear and disabled source
    issue(mk(0, 0, 0, 0, 19, 0, 1));
    issue(mk(19, 19, 1, 1, 20, 1, 0));
    issue(mk(0, 0, 0, 0, 21, 1, 1));
    issue(mk(21, 21, 0, 0, 22, 1, 0));
    issue(mk(21, 21, 1, 1, 23, 1, 0));
    issue(mk(0, 0, 0, 0, 0, 0, 0));
    issue(mk(0, 0, 0, 0, 0, 0, 0));

    for (int k = 0; k < 3000; k++) begin
      ins_t r;
      r.rs1 = REG_W'($urandom_range(0, 3));
      r.rs2 = REG_W'($urandom_range(0, 3));
      r.e1  = ($urandom_range(0, 7) != 0);
      r.e2  = ($urandom_range(0, 3) != 0);
      r.rd  = REG_W'($urandom_range(0, 3));
      r.we  = ($urandom_range(0, 7) != 0);
      r.ld  = ($urandom_range(0, 2) == 0);
      issue(r);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule